// File: doc/BRIEF.md
# Network controller command/status register block

This block is the host-visible control window of a descriptor-driven network controller. A simple register port reaches four locations. A 16-bit status word and a 16-bit command word share the first 32-bit location. A 32-bit general pointer follows, and then a write-only port register. The host places a command for the command unit (CU) or the receive unit (RU) in the command word. The block hands the command to that unit as a one-cycle request, with the pointer as its operand. It clears the opcode field once the unit accepts the command, so a host that polls until both fields read zero knows that it may issue the next command.

The status word shows the current states of both units and holds latched interrupt causes. The host clears a cause by writing a one to its bit. A mask bit and a software-interrupt trigger sit in the command word, and a level-sensitive interrupt line is driven from the unmasked causes.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After reset, all status cause bits, both opcode fields and the mask bit read 0, irq_o is low, and neither cu_valid_o nor ru_valid_o is asserted.
- R2: A one on an event input sets the matching status bit, which reads back the cycle after the event. The mapping is evt_i[5]→bit 15 (command done), evt_i[4]→bit 14 (frame received), evt_i[3]→bit 13 (CU left active), evt_i[2]→bit 12 (receiver left ready), evt_i[1]→bit 11 (management cycle done), evt_i[0]→bit 8 (flow-control pause).
- R3: Writing the status high byte clears each cause bit written as one within mask 0xFD00. Bits written as zero keep their value. An event that arrives in the same cycle as its clear wins.
- R4: Writing a one to command bit 9 sets status bit 10 (software interrupt). Command bit 9 itself reads 0.
- R5: irq_o is high exactly when any cause bit is set and command bit 8 (the mask) is 0. The mask reads back at command bit 8.
- R6: Writing a nonzero value into the CU opcode field (command bits 7:4) asserts cu_valid_o for exactly one cycle, in the cycle after the write. During that cycle cu_op_o carries the opcode and op_ptr_o carries the pointer.
- R7: The RU opcode field (command bits 2:0) behaves in the same way, through ru_valid_o and ru_op_o.
- R8: An opcode field reads zero from the cycle after its unit's acknowledge is sampled. No request is repeated while the block waits for that acknowledge.
- R9: A write to an opcode field that is still nonzero is ignored.
- R10: Status bits 7:6 show cu_state_i and status bits 5:2 show ru_state_i.
- R11: The pointer at byte offset 4 is written with per-byte enables. A write to byte offset 8 gives port_wr_o high for one cycle, with the full write data on port_data_o; this location reads as zero. The command word is the upper half of offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Byte address (0, 4, 8) |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| evt_i | input | 6 | Cause event pulses from the units |
| cu_state_i | input | 2 | Command unit state |
| ru_state_i | input | 4 | Receive unit state |
| cu_valid_o | output | 1 | CU command request pulse |
| cu_op_o | output | 4 | CU opcode |
| cu_ack_i | input | 1 | CU accepts command |
| ru_valid_o | output | 1 | RU command request pulse |
| ru_op_o | output | 3 | RU opcode |
| ru_ack_i | input | 1 | RU accepts command |
| op_ptr_o | output | 32 | Pointer operand |
| port_wr_o | output | 1 | Port register write pulse |
| port_data_o | output | 32 | Port register data |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check, on every cycle, the following:
- A request never lasts longer than one cycle.
- A busy opcode field clears after its acknowledge.
- The interrupt stays low while masked.
- A command-done event and a software-interrupt write are always latched.

Only the bench scenarios can show some other behaviours. One is the full write-one-to-clear pattern space, including the collision where an event meets its clear in the same cycle. Others are that writes to a busy field are ignored, that opcode and pointer values are correct at the moment of the request, and that partial pointer writes and port strobes behave as required.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int unsigned CAUSE_W   = 8;
  localparam logic [7:0]  CAUSE_KEEP = 8'hFD;  // status 15:8 under 0xFD00
  localparam int unsigned EVT_W     = 6;
  localparam int unsigned CU_OP_W   = 4;
  localparam int unsigned RU_OP_W   = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [3:0] addr);
    if (addr[1:0] != 2'b00) return SEL_NONE;
    case (addr[3:2])
      2'd0:    return SEL_CTRL;
      2'd1:    return SEL_PTR;
      2'd2:    return SEL_PORT;
      default: return SEL_NONE;
    endcase
  endfunction

  // cause index = status bit - 8; index 2 is software, index 1 unused
  function automatic logic [CAUSE_W-1:0] evt_to_cause(input logic [EVT_W-1:0] evt,
                                                      input logic swi);
    return {evt[5], evt[4], evt[3], evt[2], evt[1], swi, 1'b0, evt[0]};
  endfunction
endpackage

// File: rtl/nic_cause_latch.sv
module nic_cause_latch #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_live
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // set wins over clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;
    end else begin : g_dead
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/nic_cmd_slot.sv
module nic_cmd_slot #(
  parameter int unsigned OP_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [OP_W-1:0] wr_op_i,
  input  logic            ack_i,
  output logic [OP_W-1:0] op_o,
  output logic            valid_o,
  output logic            busy_o
);
  logic [OP_W-1:0] op_q;
  logic            pend_q;

  assign busy_o  = (op_q != '0);
  assign valid_o = busy_o && !pend_q;
  assign op_o    = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      pend_q <= 1'b0;
    end else if (busy_o && ack_i) begin
      op_q   <= '0;
      pend_q <= 1'b0;
    end else if (valid_o) begin
      pend_q <= 1'b1;
    end else if (wr_en_i && !busy_o) begin
      op_q   <= wr_op_i;               // writes to a busy field are dropped
    end
  end
endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_csr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic [3:0]          bus_addr_i,
  input  logic [3:0]          bus_be_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [EVT_W-1:0]    evt_i,
  input  logic [1:0]          cu_state_i,
  input  logic [3:0]          ru_state_i,
  output logic                cu_valid_o,
  output logic [CU_OP_W-1:0]  cu_op_o,
  input  logic                cu_ack_i,
  output logic                ru_valid_o,
  output logic [RU_OP_W-1:0]  ru_op_o,
  input  logic                ru_ack_i,
  output logic [31:0]         op_ptr_o,
  output logic                port_wr_o,
  output logic [31:0]         port_data_o,
  output logic                irq_o
);
  reg_sel_e sel;
  logic wr_ctrl, wr_ptr, wr_port;
  logic swi_set, mask_q;
  logic [CAUSE_W-1:0] cause_q, cause_clr;
  logic [31:0] ptr_q;
  logic cu_busy, ru_busy;
  logic [15:0] status_w, cmd_w;

  assign sel     = decode_sel(bus_addr_i);
  assign wr_ctrl = bus_wr_i && (sel == SEL_CTRL);
  assign wr_ptr  = bus_wr_i && (sel == SEL_PTR);
  assign wr_port = bus_wr_i && (sel == SEL_PORT);

  assign swi_set   = wr_ctrl && bus_be_i[3] && bus_wdata_i[25];
  assign cause_clr = (wr_ctrl && bus_be_i[1]) ? bus_wdata_i[15:8] : '0;

  nic_cause_latch #(.W(CAUSE_W), .KEEP(CAUSE_KEEP)) u_cause (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_to_cause(evt_i, swi_set)),
    .clr_i (cause_clr),
    .q_o   (cause_q)
  );

  nic_cmd_slot #(.OP_W(CU_OP_W)) u_cu_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_ctrl && bus_be_i[2]),
    .wr_op_i(bus_wdata_i[23:20]),
    .ack_i  (cu_ack_i),
    .op_o   (cu_op_o),
    .valid_o(cu_valid_o),
    .busy_o (cu_busy)
  );

  nic_cmd_slot #(.OP_W(RU_OP_W)) u_ru_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_ctrl && bus_be_i[2]),
    .wr_op_i(bus_wdata_i[18:16]),
    .ack_i  (ru_ack_i),
    .op_o   (ru_op_o),
    .valid_o(ru_valid_o),
    .busy_o (ru_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= 1'b0;
      ptr_q       <= '0;
      port_wr_o   <= 1'b0;
      port_data_o <= '0;
    end else begin
      if (wr_ctrl && bus_be_i[3]) mask_q <= bus_wdata_i[24];
      for (int b = 0; b < 4; b++)
        if (wr_ptr && bus_be_i[b]) ptr_q[8*b +: 8] <= bus_wdata_i[8*b +: 8];
      port_wr_o <= wr_port;
      if (wr_port) port_data_o <= bus_wdata_i;
    end
  end

  assign op_ptr_o = ptr_q;
  assign irq_o    = (|cause_q) && !mask_q;
  assign status_w = {cause_q, cu_state_i, ru_state_i, 2'b00};
  assign cmd_w    = {6'd0, 1'b0, mask_q, cu_op_o, 1'b0, ru_op_o};

  always_comb begin
    case (sel)
      SEL_CTRL: bus_rdata_o = {cmd_w, status_w};
      SEL_PTR:  bus_rdata_o = ptr_q;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/nic_ctrl_regs_chk.sv
module nic_ctrl_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cu_valid_o,
  input logic       ru_valid_o,
  input logic       cu_busy,
  input logic       ru_busy,
  input logic       cu_ack_i,
  input logic       ru_ack_i,
  input logic       irq_o,
  input logic       mask_q,
  input logic [5:0] evt_i,
  input logic [7:0] cause_q,
  input logic       swi_set
);
  // R6
  cu_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cu_valid_o |=> !cu_valid_o);
  // R7
  ru_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ru_valid_o |=> !ru_valid_o);
  // R8
  cu_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cu_busy && cu_ack_i) |=> !cu_busy);
  // R8
  ru_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ru_busy && ru_ack_i) |=> !ru_busy);
  // R5
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mask_q);
  // R2
  done_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[5] |=> cause_q[7]);
  // R4
  swi_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_set |=> cause_q[2]);
endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cu_valid_o(cu_valid_o),
  .ru_valid_o(ru_valid_o),
  .cu_busy   (cu_busy),
  .ru_busy   (ru_busy),
  .cu_ack_i  (cu_ack_i),
  .ru_ack_i  (ru_ack_i),
  .irq_o     (irq_o),
  .mask_q    (mask_q),
  .evt_i     (evt_i),
  .cause_q   (cause_q),
  .swi_set   (swi_set)
);

// File: tb/nic_ctrl_regs_test.sv
`timescale 1ns/1ps
module nic_ctrl_regs_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = 0, bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [5:0]  evt = 0;
  logic [1:0]  cu_state = 0;
  logic [3:0]  ru_state = 0;
  logic        cu_valid, ru_valid, cu_ack = 0, ru_ack = 0;
  logic [3:0]  cu_op;
  logic [2:0]  ru_op;
  logic [31:0] op_ptr, port_data;
  logic        port_wr, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  nic_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .evt_i(evt), .cu_state_i(cu_state), .ru_state_i(ru_state),
    .cu_valid_o(cu_valid), .cu_op_o(cu_op), .cu_ack_i(cu_ack),
    .ru_valid_o(ru_valid), .ru_op_o(ru_op), .ru_ack_i(ru_ack),
    .op_ptr_o(op_ptr), .port_wr_o(port_wr), .port_data_o(port_data),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [5:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = 0;
  endtask

  function automatic logic [7:0] evt_map(input logic [5:0] e);
    return {e[5], e[4], e[3], e[2], e[1], 1'b0, 1'b0, e[0]};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, r);
    check("R1 ctrl word", r & 32'hFFFF_FF00, 0);
    check("R1 irq", irq, 0);
    check("R1 valids", {cu_valid, ru_valid}, 0);

    // R10 state reflection sweep
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 16; s++) begin
        cu_state = c[1:0]; ru_state = s[3:0];
        rd(0, r);
        check("R10 state bits", r[7:0], {c[1:0], s[3:0], 2'b00});
      end
    cu_state = 0; ru_state = 0;

    // R2 individual events
    for (int k = 0; k < 6; k++) begin
      wr(0, 4'b0010, 32'h0000_FF00);
      pulse_evt(6'(1 << k));
      rd(0, r);
      check("R2 event latch", r[15:8], evt_map(6'(1 << k)));
    end

    // R3/R4/R5 clear-pattern sweep
    for (int p = 0; p < 256; p++) begin
      pulse_evt(6'h3F);
      wr(0, 4'b1000, 32'h0200_0000);       // R4 swi, mask 0
      wr(0, 4'b0010, 32'(p) << 8);
      rd(0, r);
      check("R3 w1c pattern", r[15:8], 8'hFD & ~8'(p));
      check("R5 irq level", irq, ((8'hFD & ~8'(p)) != 0));
    end
    rd(0, r);
    check("R4 bit9 reads 0", r[25], 0);

    // R3 event wins over simultaneous clear
    wr(0, 4'b0010, 32'h0000_FF00);
    @(negedge clk);
    bus_wr = 1; bus_addr = 0; bus_be = 4'b0010; bus_wdata = 32'h0000_8000; evt = 6'h20;
    @(negedge clk);
    bus_wr = 0; bus_be = 0; evt = 0;
    rd(0, r);
    check("R3 set beats clear", r[15:8], 8'h80);

    // R5 mask
    wr(0, 4'b1000, 32'h0100_0000);
    rd(0, r);
    check("R5 mask readback", r[24], 1);
    check("R5 irq masked", irq, 0);
    wr(0, 4'b1000, 32'h0000_0000);
    check("R5 irq unmasked", irq, 1);
    wr(0, 4'b0010, 32'h0000_FF00);
    check("R5 irq after clear", irq, 0);

    // R6/R8 CU opcode sweep with ack delays
    for (int op = 1; op < 8; op++) begin
      wr(4, 4'hF, 32'hA000_0000 + op);
      wr(0, 4'b0100, 32'(op) << 20);
      check("R6 cu valid", cu_valid, 1);
      check("R6 cu op", cu_op, op);
      check("R6 cu ptr", op_ptr, 32'hA000_0000 + op);
      for (int d = 0; d < op % 3; d++) begin
        @(negedge clk);
        check("R8 no repeat", cu_valid, 0);
        rd(0, r);
        check("R8 field held", r[23:20], op);
      end
      cu_ack = 1;
      @(negedge clk);
      cu_ack = 0;
      rd(0, r);
      check("R8 cu field cleared", r[23:16], 0);
      check("R8 cu valid low", cu_valid, 0);
    end

    // R7/R8 RU opcode sweep
    for (int op = 1; op < 8; op++) begin
      wr(4, 4'hF, 32'h5000_0000 + op);
      wr(0, 4'b0100, 32'(op) << 16);
      check("R7 ru valid", ru_valid, 1);
      check("R7 ru op", ru_op, op);
      check("R7 ru ptr", op_ptr, 32'h5000_0000 + op);
      check("R7 cu idle", cu_valid, 0);
      if (op[0]) begin
        @(negedge clk);
        check("R8 ru no repeat", ru_valid, 0);
      end
      ru_ack = 1;
      @(negedge clk);
      ru_ack = 0;
      rd(0, r);
      check("R8 ru field cleared", r[18:16], 0);
    end

    // R9 write to busy field ignored
    wr(0, 4'b0100, 32'h0010_0000);
    @(negedge clk);
    wr(0, 4'b0100, 32'h0020_0000);
    rd(0, r);
    check("R9 busy field kept", r[23:20], 1);
    check("R9 no new request", cu_valid, 0);
    cu_ack = 1;
    @(negedge clk);
    cu_ack = 0;
    rd(0, r);
    check("R9 cleared after ack", r[23:20], 0);

    // R11 pointer byte enables and port register
    wr(4, 4'hF, 32'h1122_3344);
    wr(4, 4'b0101, 32'hAABB_CCDD);
    rd(4, r);
    check("R11 ptr byte enables", r, 32'h11BB_33DD);
    wr(8, 4'hF, 32'hDEAD_BEEF);
    check("R11 port strobe", port_wr, 1);
    check("R11 port data", port_data, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R11 port strobe single", port_wr, 0);
    rd(8, r);
    check("R11 port reads zero", r, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule